// File: doc/BRIEF.md
# Two-Port Output-Queued Blocking Switch Element

This block is one 2x2 switching element for a clocked, self-routing multistage network. Packets are fixed size: a destination tag in the upper bits and a payload below it. Each of the two inputs offers at most one packet per cycle. The element reads the tag bit that belongs to its stage and places the packet in the queue of the upper or the lower output port. Each output queue holds `DEPTH` packets and presents its oldest entry downstream over a valid/ready pair.

Admission depends on the space left in the target queue. When both inputs aim at the same queue and it has room for two, both packets enter together. When it has room for only one, a free-running pseudo-random bit picks the winner. When it is full, both are turned away. A refused packet is not consumed. The upstream stage keeps it at its head and offers it again to the same port. A packet that has been accepted is never lost.

Top module: `swch2x2`

## Requirements
- R1: After reset both output queues are empty, so `out0_valid` and `out1_valid` are low.
- R2: The packet occupies `{tag[TAG_W-1:0], payload[DATA_W-1:0]}`. The element with stage index `STAGE_IDX` reads tag bit `TAG_W-1-STAGE_IDX`, so stage 0 reads the most significant tag bit. A 0 routes the packet to output 0 (upper) and a 1 routes it to output 1 (lower).
- R3: A single valid packet aimed at a queue with at least one free slot is accepted (`inN_ready` high in that cycle). It is refused if that queue is full.
- R4: When both inputs aim at the same queue and it has at least two free slots, both are accepted in the same cycle. The input 0 packet is queued ahead of the input 1 packet.
- R5: When both inputs aim at the same queue and it has exactly one free slot, exactly one of them is accepted.
- R6: When both inputs aim at a full queue, neither is accepted.
- R7: Free space is `DEPTH` minus the occupancy at the start of the cycle. A packet leaving a queue in a cycle does not make room for that cycle's arrivals.
- R8: Each output delivers its packets in arrival order without loss or duplication. While `outN_valid` is high and `outN_ready` is low, the offered packet stays unchanged.
- R9: Over repeated one-slot ties, each input wins at least once.
- R10: Packets aimed at different outputs are judged independently, and both can be accepted in the same cycle.
- R11: `inN_ready` is low whenever `inN_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in0_valid | input | 1 | Input 0 offers a packet |
| in0_pkt | input | PKT_W | Input 0 packet {tag, payload} |
| in0_ready | output | 1 | Input 0 packet accepted this cycle |
| in1_valid | input | 1 | Input 1 offers a packet |
| in1_pkt | input | PKT_W | Input 1 packet {tag, payload} |
| in1_ready | output | 1 | Input 1 packet accepted this cycle |
| out0_valid | output | 1 | Upper queue has a head packet |
| out0_pkt | output | PKT_W | Upper queue head packet |
| out0_ready | input | 1 | Downstream takes the upper head |
| out1_valid | output | 1 | Lower queue has a head packet |
| out1_pkt | output | PKT_W | Lower queue head packet |
| out1_ready | input | 1 | Downstream takes the lower head |

## Verification
Admission to a queue and departure from that same queue can fall in one cycle. In that cycle the admission decision must still use the occupancy from before the departure. The bench provokes this by filling a queue while its output is stalled. It then raises the output ready in the same cycle that a new packet aims at that queue, and a one-slot tie is set up the same way. A model queue per output, updated from the accepted and departing packets, gives the expected readies and checks every later head value.

// File: rtl/swch_pkg.sv
package swch_pkg;

    localparam int TAG_W  = 3;
    localparam int DATA_W = 8;
    localparam int PKT_W  = TAG_W + DATA_W;
    localparam int RND_W  = 16;

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] payload;
    } pkt_t;

    typedef enum logic [1:0] {
        ADM_IDLE,
        ADM_ALL,
        ADM_DRAW,
        ADM_BLOCK
    } adm_e;

    // Next state of the tie-break generator (x^16 + x^14 + x^13 + x^11)
    function automatic logic [RND_W-1:0] rnd_step(input logic [RND_W-1:0] s);
        logic fb;
        fb = s[15] ^ s[13] ^ s[12] ^ s[10];
        return {s[RND_W-2:0], fb};
    endfunction

    // Admission decision for one output queue.
    // req[i]: input i aims at this queue; has1/has2: one / two slots free.
    function automatic logic [1:0] arbitrate(input logic [1:0] req,
                                             input logic       has1,
                                             input logic       has2,
                                             input logic       pick0);
        adm_e       mode;
        logic [1:0] g;
        if (req == 2'b00)
            mode = ADM_IDLE;
        else if (req == 2'b11)
            mode = has2 ? ADM_ALL : (has1 ? ADM_DRAW : ADM_BLOCK);
        else
            mode = has1 ? ADM_ALL : ADM_BLOCK;
        case (mode)
            ADM_ALL:  g = req;
            ADM_DRAW: g = pick0 ? 2'b01 : 2'b10;
            default:  g = 2'b00;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/swch_lfsr.sv
module swch_lfsr
    import swch_pkg::*;
#(
    parameter logic [RND_W-1:0] SEED = 16'hACE1
) (
    input  logic clk,
    input  logic rst,
    output logic pick0
);
    logic [RND_W-1:0] state_q;

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= SEED;
        else
            state_q <= rnd_step(state_q);
    end

    assign pick0 = state_q[0];
endmodule

// File: rtl/swch_admit.sv
module swch_admit
    import swch_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic [1:0]       in_valid,
    input  logic [1:0]       in_dst,
    input  logic [CNT_W-1:0] free0,
    input  logic [CNT_W-1:0] free1,
    input  logic             pick0,
    output logic [1:0]       grant,
    output logic [1:0]       port_hit0,
    output logic [1:0]       port_hit1
);
    logic [3:0] pg;

    genvar p;
    generate
        for (p = 0; p < 2; p++) begin : g_port
            logic [1:0]       req;
            logic [CNT_W-1:0] fr;
            assign fr     = (p == 0) ? free0 : free1;
            assign req[0] = in_valid[0] && (in_dst[0] == p[0]);
            assign req[1] = in_valid[1] && (in_dst[1] == p[0]);
            assign pg[2*p +: 2] = arbitrate(req, fr != '0,
                                            fr >= CNT_W'(2), pick0);
        end
    endgenerate

    assign port_hit0 = pg[1:0];
    assign port_hit1 = pg[3:2];
    assign grant     = pg[1:0] | pg[3:2];
endmodule

// File: rtl/swch_ofifo.sv
module swch_ofifo #(
    parameter int DEPTH = 4,
    parameter int W     = 11,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       push_n,
    input  logic [W-1:0]     push_a,
    input  logic [W-1:0]     push_b,
    input  logic             pop,
    output logic [W-1:0]     head,
    output logic             nonempty,
    output logic [CNT_W-1:0] occ
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wp_q, rp_q;
    logic [CNT_W-1:0] occ_q;

    function automatic logic [PTR_W-1:0] wrap_add(input logic [PTR_W-1:0] ptr,
                                                  input int step);
        int s;
        s = int'(ptr) + step;
        if (s >= DEPTH) s = s - DEPTH;
        return PTR_W'(s);
    endfunction

    always_ff @(posedge clk) begin
        if (push_n != 2'd0) mem[wp_q] <= push_a;
        if (push_n == 2'd2) mem[wrap_add(wp_q, 1)] <= push_b;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q  <= '0;
            rp_q  <= '0;
            occ_q <= '0;
        end else begin
            wp_q  <= wrap_add(wp_q, int'(push_n));
            if (pop) rp_q <= wrap_add(rp_q, 1);
            occ_q <= occ_q + CNT_W'(push_n) - CNT_W'(pop);
        end
    end

    assign head     = mem[rp_q];
    assign nonempty = occ_q != '0;
    assign occ      = occ_q;
endmodule

// File: rtl/swch2x2.sv
module swch2x2
    import swch_pkg::*;
#(
    parameter int               DEPTH     = 4,
    parameter int               STAGE_IDX = 0,
    parameter logic [RND_W-1:0] SEED      = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in0_valid,
    input  logic [PKT_W-1:0] in0_pkt,
    output logic             in0_ready,
    input  logic             in1_valid,
    input  logic [PKT_W-1:0] in1_pkt,
    output logic             in1_ready,
    output logic             out0_valid,
    output logic [PKT_W-1:0] out0_pkt,
    input  logic             out0_ready,
    output logic             out1_valid,
    output logic [PKT_W-1:0] out1_pkt,
    input  logic             out1_ready
);
    localparam int CNT_W   = $clog2(DEPTH + 1);
    localparam int TAG_BIT = TAG_W - 1 - STAGE_IDX;

    pkt_t             pin [2];
    logic [1:0]       dst;
    logic [1:0]       grant;
    logic [1:0]       hit [2];
    logic [CNT_W-1:0] occ [2];
    logic [CNT_W-1:0] free_sl [2];
    logic [1:0]       ovalid;
    logic [1:0]       ordy;
    logic [PKT_W-1:0] ohead [2];
    logic             pick0;

    assign pin[0] = pkt_t'(in0_pkt);
    assign pin[1] = pkt_t'(in1_pkt);
    assign dst[0] = pin[0].tag[TAG_BIT];
    assign dst[1] = pin[1].tag[TAG_BIT];
    assign ordy   = {out1_ready, out0_ready};

    swch_lfsr #(.SEED(SEED)) u_rnd (
        .clk   (clk),
        .rst   (rst),
        .pick0 (pick0)
    );

    swch_admit #(.CNT_W(CNT_W)) u_admit (
        .in_valid  ({in1_valid, in0_valid}),
        .in_dst    (dst),
        .free0     (free_sl[0]),
        .free1     (free_sl[1]),
        .pick0     (pick0),
        .grant     (grant),
        .port_hit0 (hit[0]),
        .port_hit1 (hit[1])
    );

    genvar p;
    generate
        for (p = 0; p < 2; p++) begin : g_q
            logic [1:0]       n;
            logic [PKT_W-1:0] first;
            assign free_sl[p] = CNT_W'(DEPTH) - occ[p];
            assign n     = {1'b0, hit[p][0]} + {1'b0, hit[p][1]};
            assign first = hit[p][0] ? PKT_W'(pin[0]) : PKT_W'(pin[1]);
            swch_ofifo #(.DEPTH(DEPTH), .W(PKT_W)) u_fifo (
                .clk      (clk),
                .rst      (rst),
                .push_n   (n),
                .push_a   (first),
                .push_b   (PKT_W'(pin[1])),
                .pop      (ovalid[p] && ordy[p]),
                .head     (ohead[p]),
                .nonempty (ovalid[p]),
                .occ      (occ[p])
            );
        end
    endgenerate

    assign in0_ready  = grant[0];
    assign in1_ready  = grant[1];
    assign out0_valid = ovalid[0];
    assign out1_valid = ovalid[1];
    assign out0_pkt   = ohead[0];
    assign out1_pkt   = ohead[1];
endmodule

// File: rtl/swch2x2_chk.sv
module swch2x2_chk
    import swch_pkg::*;
#(
    parameter int DEPTH     = 4,
    parameter int STAGE_IDX = 0,
    localparam int CNT_W    = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             in0_valid,
    input logic [PKT_W-1:0] in0_pkt,
    input logic             in0_ready,
    input logic             in1_valid,
    input logic [PKT_W-1:0] in1_pkt,
    input logic             in1_ready,
    input logic             out0_valid,
    input logic [PKT_W-1:0] out0_pkt,
    input logic             out0_ready,
    input logic [CNT_W-1:0] occ [2]
);
    localparam int BITPOS = DATA_W + TAG_W - 1 - STAGE_IDX;

    logic d0, d1, same0;
    assign d0    = in0_pkt[BITPOS];
    assign d1    = in1_pkt[BITPOS];
    assign same0 = in0_valid && in1_valid && !d0 && !d1;

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
        occ[0] <= CNT_W'(DEPTH) && occ[1] <= CNT_W'(DEPTH));

    p_head_hold_r8: assert property (@(posedge clk) disable iff (rst)
        out0_valid && !out0_ready |=> out0_valid && $stable(out0_pkt));

    p_ready_needs_valid_r11: assert property (@(posedge clk) disable iff (rst)
        (!in0_valid |-> !in0_ready) and (!in1_valid |-> !in1_ready));

    p_full_refuse_r6: assert property (@(posedge clk) disable iff (rst)
        in0_valid && !d0 && occ[0] == CNT_W'(DEPTH) |-> !in0_ready);

    p_tie_one_r5: assert property (@(posedge clk) disable iff (rst)
        same0 && occ[0] == CNT_W'(DEPTH - 1) |-> $countones({in0_ready, in1_ready}) == 1);

    p_pair_enter_r4: assert property (@(posedge clk) disable iff (rst)
        same0 && occ[0] <= CNT_W'(DEPTH - 2) |-> in0_ready && in1_ready);

    p_occ_step_r7: assert property (@(posedge clk) disable iff (rst)
        same0 && in0_ready && in1_ready && !(out0_valid && out0_ready)
        |=> occ[0] == $past(occ[0]) + CNT_W'(2));
endmodule

bind swch2x2 swch2x2_chk #(.DEPTH(DEPTH), .STAGE_IDX(STAGE_IDX)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in0_valid  (in0_valid),
    .in0_pkt    (in0_pkt),
    .in0_ready  (in0_ready),
    .in1_valid  (in1_valid),
    .in1_pkt    (in1_pkt),
    .in1_ready  (in1_ready),
    .out0_valid (out0_valid),
    .out0_pkt   (out0_pkt),
    .out0_ready (out0_ready),
    .occ        (occ)
);

// File: tb/swch2x2_bench.sv
module swch2x2_bench;
    import swch_pkg::*;

    localparam int DEPTH = 4;
    localparam int STAGE = 1;
    localparam int BITP  = DATA_W + TAG_W - 1 - STAGE;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in0_valid = 1'b0, in1_valid = 1'b0;
    logic [PKT_W-1:0] in0_pkt = '0, in1_pkt = '0;
    logic             in0_ready, in1_ready;
    logic             out0_valid, out1_valid;
    logic [PKT_W-1:0] out0_pkt, out1_pkt;
    logic             out0_ready = 1'b0, out1_ready = 1'b0;

    always #4 clk = ~clk;

    swch2x2 #(.DEPTH(DEPTH), .STAGE_IDX(STAGE)) u_swch2x2 (
        .clk(clk), .rst(rst),
        .in0_valid(in0_valid), .in0_pkt(in0_pkt), .in0_ready(in0_ready),
        .in1_valid(in1_valid), .in1_pkt(in1_pkt), .in1_ready(in1_ready),
        .out0_valid(out0_valid), .out0_pkt(out0_pkt), .out0_ready(out0_ready),
        .out1_valid(out1_valid), .out1_pkt(out1_pkt), .out1_ready(out1_ready)
    );

    int n_chk = 0, n_bad = 0, wins0 = 0, wins1 = 0;
    bit done = 0;
    logic [PKT_W-1:0] mq0 [$];
    logic [PKT_W-1:0] mq1 [$];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int qsize(input int p);
        return (p == 0) ? mq0.size() : mq1.size();
    endfunction

    function automatic logic [PKT_W-1:0] mk(input bit port, input logic [7:0] pay);
        logic [PKT_W-1:0] k;
        k = {TAG_W'($urandom), pay};
        k[BITP] = port;
        return k;
    endfunction

    // One cycle: drive, check against the model, advance the model.
    task automatic cyc(input bit v0, input logic [PKT_W-1:0] k0,
                       input bit v1, input logic [PKT_W-1:0] k1,
                       input bit r0, input bit r1);
        int d0, d1, f0, f1;
        @(negedge clk);
        in0_valid = v0; in0_pkt = k0; in1_valid = v1; in1_pkt = k1;
        out0_ready = r0; out1_ready = r1;
        #1;
        chk(out0_valid == (mq0.size() > 0), "R8 out0_valid", out0_valid, mq0.size() > 0);
        chk(out1_valid == (mq1.size() > 0), "R8 out1_valid", out1_valid, mq1.size() > 0);
        if (mq0.size() > 0) chk(out0_pkt == mq0[0], "R2 R8 out0 head", out0_pkt, mq0[0]);
        if (mq1.size() > 0) chk(out1_pkt == mq1[0], "R2 R8 out1 head", out1_pkt, mq1[0]);
        d0 = int'(k0[BITP]); d1 = int'(k1[BITP]);
        f0 = DEPTH - qsize(d0); f1 = DEPTH - qsize(d1);
        if (!v0) chk(!in0_ready, "R11 in0", in0_ready, 0);
        if (!v1) chk(!in1_ready, "R11 in1", in1_ready, 0);
        if (v0 && v1 && d0 == d1) begin
            if (f0 >= 2) begin
                chk(in0_ready && in1_ready, "R4 pair", {in0_ready, in1_ready}, 3);
            end else if (f0 == 1) begin
                chk(in0_ready ^ in1_ready, "R5 tie", {in0_ready, in1_ready}, 1);
                if (in0_ready) wins0++;
                if (in1_ready) wins1++;
            end else begin
                chk(!in0_ready && !in1_ready, "R6 R7 full", {in0_ready, in1_ready}, 0);
            end
        end else begin
            if (v0) chk(in0_ready == (f0 >= 1), (v1 ? "R10 in0" : "R3 R7 in0"), in0_ready, f0 >= 1);
            if (v1) chk(in1_ready == (f1 >= 1), (v0 ? "R10 in1" : "R3 R7 in1"), in1_ready, f1 >= 1);
        end
        if (out0_valid && r0 && mq0.size() > 0) void'(mq0.pop_front());
        if (out1_valid && r1 && mq1.size() > 0) void'(mq1.pop_front());
        if (v0 && in0_ready) begin if (d0 == 0) mq0.push_back(k0); else mq1.push_back(k0); end
        if (v1 && in1_ready) begin if (d1 == 0) mq0.push_back(k1); else mq1.push_back(k1); end
    endtask

    task automatic idle(input bit r0, input bit r1);
        cyc(1'b0, '0, 1'b0, '0, r0, r1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog R8 actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        chk(!out0_valid && !out1_valid, "R1 reset outputs", {out1_valid, out0_valid}, 0);
        idle(0, 0);
        // R2: routing by tag bit
        cyc(1, mk(0, 8'h11), 0, '0, 0, 0);
        cyc(1, mk(1, 8'h22), 0, '0, 0, 0);
        idle(1, 1);
        idle(0, 0);
        // R10: different outputs together
        cyc(1, mk(1, 8'h33), 1, mk(0, 8'h44), 0, 0);
        idle(1, 1);
        idle(0, 0);
        // R4: pair into empty queue, order checked on drain
        cyc(1, mk(0, 8'h55), 1, mk(0, 8'h66), 0, 0);
        idle(1, 0); idle(1, 0); idle(0, 0);
        // Fill upper queue, then R6 and R7
        for (int i = 0; i < DEPTH; i++) cyc(1, mk(0, 8'(i)), 0, '0, 0, 0);
        cyc(1, mk(0, 8'hA0), 1, mk(0, 8'hA1), 0, 0);
        cyc(1, mk(0, 8'hA2), 0, '0, 1, 0);
        cyc(1, mk(0, 8'hA3), 1, mk(0, 8'hA4), 0, 0);
        // R5/R9: repeated one-slot ties
        for (int i = 0; i < 60; i++) begin
            cyc(1, mk(0, 8'(i)), 1, mk(0, 8'(i + 100)), 0, 0);
            idle(1, 0);
        end
        for (int i = 0; i < DEPTH + 2; i++) idle(1, 1);
        // Random traffic
        for (int i = 0; i < 4000; i++)
            cyc(1'($urandom), mk(1'($urandom), 8'($urandom)),
                1'($urandom), mk(1'($urandom), 8'($urandom)),
                ($urandom % 3) != 0, ($urandom % 3) == 0);
        for (int i = 0; i < DEPTH + 2; i++) idle(1, 1);
        chk(wins0 > 0, "R9 input0 wins", wins0, 1);
        chk(wins1 > 0, "R9 input1 wins", wins1, 1);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule